// File: doc/BRIEF.md
# Programmable Interrupt Priority Resolver

This block decides whether the CPU is interrupted and which of six request lines wins. A mask register has one enable bit per source and a master enable bit. A priority register sets the order of three groups of two sources each, and can swap the order of the two sources inside each group. The interrupt output is combinational: it is the pending vector ANDed with the enables and the master enable, and it is also gated by a valid group-order code. When the CPU acknowledges, the index of the winning source is captured in a register.

The master enable is driven by the instruction flow. An enable strobe sets it and a disable strobe clears it. Taking an interrupt (the acknowledge strobe) clears it, and a return-from-interrupt strobe sets it again. After reset every enable is zero and the group-order code is unused, so software must program both registers before any interrupt can be raised. Vector fetch, stacking and clearing of pending bits are handled elsewhere.

Top module: `irq_prio_resolver`

## Requirements
- R1: Reset, which is synchronous and active-low, clears all six source enables, the master enable, the priority register and the captured index. While reset is held and in the first cycle after it, `irq_o` is 0 and `irq_id_o` is 0.
- R2: Mask write bit k (k = 0..5) enables source k. A pending source whose enable bit is 0 never makes `irq_o` high. Mask write bit 6 is ignored.
- R3: Mask write bit 7 is the master enable. While it is 0, `irq_o` is 0 whatever the pending bits and the source enables are.
- R4: `ei_i` sets the master enable and `di_i` clears it. When both are high in the same cycle, the clear wins.
- R5: `ack_i` clears the master enable. `reti_i` sets it unless `ack_i` or `di_i` is high in the same cycle. Any clear strobe overrides a set strobe and a mask write. A set strobe overrides the bit 7 value of a mask write.
- R6: The group-order code is {prio bit 4, prio bit 3, prio bit 0}. The groups, listed from highest to lowest priority, are: 001 gives C,A,B; 010 gives A,B,C; 011 gives A,C,B; 100 gives B,C,A; 101 gives C,B,A; 110 gives B,A,C.
- R7: When the group-order code is 000 or 111, `irq_o` is 0.
- R8: Group B holds sources 0 and 2. Prio bit 2 = 0 ranks source 2 first, and 1 ranks source 0 first.
- R9: Group A holds sources 3 and 5. Prio bit 5 = 0 ranks source 5 first, and 1 ranks source 3 first.
- R10: Group C holds sources 1 and 4. Prio bit 1 = 0 ranks source 1 first, and 1 ranks source 4 first.
- R11: At a clock edge where `ack_i` and `irq_o` are both high, `irq_id_o` loads the index of the highest-ranked source that is pending and enabled. The new value is visible after that edge. At every other edge it holds its value.
- R12: A mask or priority write takes effect at the next clock edge, even while the master enable is set. `irq_o` follows `irq_pend_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pend_i | input | 6 | Pending request per source |
| mask_wr_i | input | 1 | Write strobe for the mask register |
| mask_wdata_i | input | 8 | Mask data: bits 0..5 are source enables, bit 7 is the master enable |
| prio_wr_i | input | 1 | Write strobe for the priority register |
| prio_wdata_i | input | 6 | Priority data: group-order code and in-group swap bits |
| ei_i | input | 1 | Set master enable |
| di_i | input | 1 | Clear master enable |
| ack_i | input | 1 | Interrupt taken: capture winner, clear master enable |
| reti_i | input | 1 | Return from interrupt: set master enable |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_id_o | output | 3 | Index of the source captured on acknowledge |

## Verification
`irq_o` has no latency from `irq_pend_i`. Register writes and the master enable strobes change it one edge after the strobe is sampled. `irq_id_o` changes one edge after an acknowledge. The bench drives its inputs just after each falling edge. A behavioural model updates on the rising edge from those same inputs. Both outputs are compared with the model at every falling edge, before the inputs move, so every result is sampled exactly one edge after the cause. The priority sweep covers all six group orders, all eight swap combinations and all 63 non-empty pending patterns, with one acknowledge and one return per pattern.

// File: rtl/irq_prio_pkg.sv
// Shared constants and helper functions for the interrupt priority resolver.
// Assumes six sources grouped in three pairs; the group tables are fixed by
// the priority register layout.
package irq_prio_pkg;

    localparam int NUM_SRC  = 6;
    localparam int NUM_GRP  = NUM_SRC / 2;
    localparam int ID_W     = $clog2(NUM_SRC);
    localparam int GRP_W    = 2;
    localparam int CODE_W   = 3;
    localparam int PRIO_W   = 6;
    localparam int MASK_W   = NUM_SRC + 2;

    localparam logic [GRP_W-1:0] GRP_A = 2'd0;
    localparam logic [GRP_W-1:0] GRP_B = 2'd1;
    localparam logic [GRP_W-1:0] GRP_C = 2'd2;

    // Group-order code from the priority register bits {4,3,0}.
    function automatic logic [CODE_W-1:0] order_code(input logic [PRIO_W-1:0] prio);
        return {prio[4], prio[3], prio[0]};
    endfunction

    // Codes 000 and 111 are unused and block all requests.
    function automatic logic code_ok(input logic [CODE_W-1:0] code);
        return (code != 3'b000) && (code != 3'b111);
    endfunction

    // Group occupying a given rank (0 = highest) for a group-order code.
    function automatic logic [GRP_W-1:0] rank_grp(input logic [CODE_W-1:0] code,
                                                  input int rank);
        logic [3*GRP_W-1:0] ord;
        case (code)
            3'b001:  ord = {GRP_C, GRP_A, GRP_B};
            3'b010:  ord = {GRP_A, GRP_B, GRP_C};
            3'b011:  ord = {GRP_A, GRP_C, GRP_B};
            3'b100:  ord = {GRP_B, GRP_C, GRP_A};
            3'b101:  ord = {GRP_C, GRP_B, GRP_A};
            3'b110:  ord = {GRP_B, GRP_A, GRP_C};
            default: ord = {GRP_A, GRP_B, GRP_C};
        endcase
        return ord[(2-rank)*GRP_W +: GRP_W];
    endfunction

    // Source ranked first inside a group when its swap bit is 0.
    function automatic logic [ID_W-1:0] grp_first(input int g);
        case (g)
            0:       return 3'd5;
            1:       return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

    // Source ranked second inside a group when its swap bit is 0.
    function automatic logic [ID_W-1:0] grp_second(input int g);
        case (g)
            0:       return 3'd3;
            1:       return 3'd0;
            default: return 3'd4;
        endcase
    endfunction

    // Priority register bit that swaps the pair inside a group.
    function automatic int grp_swap_pos(input int g);
        case (g)
            0:       return 5;
            1:       return 2;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/irq_mask_reg.sv
// Mask register: per-source enables plus a master enable.
// Assumes single-cycle strobes. Clear strobes (disable, acknowledge) beat set
// strobes (enable, return), which beat the bit 7 value of a mask write.
module irq_mask_reg #(
    parameter int NUM_SRC = 6,
    localparam int MASK_W = NUM_SRC + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [MASK_W-1:0]  wdata_i,
    input  logic               set_i,
    input  logic               clr_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic               master_o
);

    logic unused_bit;
    assign unused_bit = wdata_i[NUM_SRC];

    // Source enable bits load on a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o <= '0;
        end else if (wr_i) begin
            en_o <= wdata_i[NUM_SRC-1:0];
        end
    end

    // Master enable follows strobe priority: clear, set, then write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_o <= 1'b0;
        end else if (clr_i) begin
            master_o <= 1'b0;
        end else if (set_i) begin
            master_o <= 1'b1;
        end else if (wr_i) begin
            master_o <= wdata_i[MASK_W-1];
        end
    end

endmodule

// File: rtl/irq_prio_reg.sv
// Priority register holding the group-order code and in-group swap bits.
// Assumes writes are allowed at any time; reset loads the unused code 000.
module irq_prio_reg #(
    parameter int PRIO_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [PRIO_W-1:0] wdata_i,
    output logic [PRIO_W-1:0] prio_o
);

    // Load the priority value on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_o <= '0;
        end else if (wr_i) begin
            prio_o <= wdata_i;
        end
    end

endmodule

// File: rtl/irq_pair_order.sv
// Orders the two sources of one group from a swap bit.
// Assumes the default order places src_a_i first.
module irq_pair_order #(
    parameter int ID_W = 3
) (
    input  logic [ID_W-1:0] src_a_i,
    input  logic [ID_W-1:0] src_b_i,
    input  logic            swap_i,
    output logic [ID_W-1:0] first_o,
    output logic [ID_W-1:0] second_o
);

    // Exchange the pair when the swap bit is set.
    always_comb begin
        first_o  = swap_i ? src_b_i : src_a_i;
        second_o = swap_i ? src_a_i : src_b_i;
    end

endmodule

// File: rtl/irq_arbiter.sv
// Combinational priority arbiter: builds the full source ranking from the
// group-order code and the swap bits, then picks the first requesting source.
// Assumes req_i is already qualified by the source enables.
module irq_arbiter
    import irq_prio_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    localparam int NGRP = NSRC / 2,
    localparam int IW   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]   req_i,
    input  logic [PRIO_W-1:0] prio_i,
    output logic              hit_o,
    output logic [IW-1:0]     win_o
);

    logic [IW-1:0] pair_first  [NGRP];
    logic [IW-1:0] pair_second [NGRP];
    logic [IW-1:0] rank_list   [NSRC];
    logic [CODE_W-1:0] code;

    assign code = order_code(prio_i);

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_pair
            irq_pair_order #(.ID_W(IW)) u_pair (
                .src_a_i  (IW'(grp_first(g))),
                .src_b_i  (IW'(grp_second(g))),
                .swap_i   (prio_i[grp_swap_pos(g)]),
                .first_o  (pair_first[g]),
                .second_o (pair_second[g])
            );
        end
    endgenerate

    // Lay out the six sources in rank order, group by group.
    always_comb begin
        for (int r = 0; r < NGRP; r++) begin
            rank_list[2*r]   = pair_first[rank_grp(code, r)];
            rank_list[2*r+1] = pair_second[rank_grp(code, r)];
        end
    end

    // Pick the first requesting source in rank order.
    always_comb begin
        hit_o = 1'b0;
        win_o = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (!hit_o && req_i[rank_list[k]]) begin
                hit_o = 1'b1;
                win_o = rank_list[k];
            end
        end
    end

endmodule

// File: rtl/irq_prio_resolver.sv
// Top of the interrupt priority resolver. Qualifies the pending sources with
// the mask, raises the CPU request combinationally, and captures the winning
// index on acknowledge. Assumes pending bits are cleared outside this block.
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    localparam int IW  = $clog2(NSRC),
    localparam int MW  = NSRC + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_pend_i,
    input  logic              mask_wr_i,
    input  logic [MW-1:0]     mask_wdata_i,
    input  logic              prio_wr_i,
    input  logic [PRIO_W-1:0] prio_wdata_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              ack_i,
    input  logic              reti_i,
    output logic              irq_o,
    output logic [IW-1:0]     irq_id_o
);

    logic [NSRC-1:0]   en_q;
    logic              master_q;
    logic [PRIO_W-1:0] prio_q;
    logic [NSRC-1:0]   qual_req;
    logic              arb_hit;
    logic [IW-1:0]     arb_win;

    irq_mask_reg #(.NUM_SRC(NSRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (mask_wr_i),
        .wdata_i  (mask_wdata_i),
        .set_i    (ei_i | reti_i),
        .clr_i    (di_i | ack_i),
        .en_o     (en_q),
        .master_o (master_q)
    );

    irq_prio_reg #(.PRIO_W(PRIO_W)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (prio_wr_i),
        .wdata_i (prio_wdata_i),
        .prio_o  (prio_q)
    );

    assign qual_req = irq_pend_i & en_q;

    irq_arbiter #(.NSRC(NSRC)) u_arb (
        .req_i  (qual_req),
        .prio_i (prio_q),
        .hit_o  (arb_hit),
        .win_o  (arb_win)
    );

    // Request to the CPU: enabled pending source, master on, valid code.
    always_comb begin
        irq_o = arb_hit && master_q && code_ok(order_code(prio_q));
    end

    // Capture the winning index when the CPU takes the interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_id_o <= '0;
        end else if (ack_i && irq_o) begin
            irq_id_o <= arb_win;
        end
    end

endmodule

// File: rtl/irq_prio_resolver_chk.sv
// Assertion checker for the interrupt priority resolver, bound to its top.
module irq_prio_resolver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] irq_pend_i,
    input logic [5:0] en_q,
    input logic       master_q,
    input logic [5:0] prio_q,
    input logic       ei_i,
    input logic       di_i,
    input logic       ack_i,
    input logic       reti_i,
    input logic       irq_o,
    input logic [2:0] irq_id_o
);

    logic code_used;
    assign code_used = !(prio_q[4] == prio_q[3] && prio_q[3] == prio_q[0]);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_id_o == 3'd0) && !irq_o);

    // R2
    src_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((irq_pend_i & en_q) != 6'd0));

    // R3
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_q |-> !irq_o);

    // R4
    di_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        di_i |=> !master_q);

    // R4
    ei_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ei_i && !di_i && !ack_i |=> master_q);

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !master_q);

    // R5
    reti_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i && !ack_i && !di_i |=> master_q);

    // R7
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_used |-> !irq_o);

    // R11
    id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && irq_o) |=> $stable(irq_id_o));

    // R11
    id_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i && irq_o |=> ((($past(irq_pend_i & en_q)) >> irq_id_o) & 6'd1) != 6'd0);

endmodule

bind irq_prio_resolver irq_prio_resolver_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_pend_i (irq_pend_i),
    .en_q       (en_q),
    .master_q   (master_q),
    .prio_q     (prio_q),
    .ei_i       (ei_i),
    .di_i       (di_i),
    .ack_i      (ack_i),
    .reti_i     (reti_i),
    .irq_o      (irq_o),
    .irq_id_o   (irq_id_o)
);

// File: tb/irq_prio_resolver_bench.sv
// Self-checking bench with a behavioural reference model compared each cycle.
module irq_prio_resolver_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] pend;
    logic       mwr;
    logic [7:0] mdata;
    logic       pwr;
    logic [5:0] pdata;
    logic       ei, di, ack, reti;
    logic       irq;
    logic [2:0] id;

    int    n_chk  = 0;
    int    n_fail = 0;
    int    n_cyc  = 0;
    string cur_req = "R1";

    // Reference model state
    logic [5:0] m_en;
    logic       m_master;
    logic [5:0] m_prio;
    logic [2:0] m_id;
    bit         started = 0;

    always #4 clk = ~clk;

    irq_prio_resolver u_irq_prio_resolver (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_pend_i   (pend),
        .mask_wr_i    (mwr),
        .mask_wdata_i (mdata),
        .prio_wr_i    (pwr),
        .prio_wdata_i (pdata),
        .ei_i         (ei),
        .di_i         (di),
        .ack_i        (ack),
        .reti_i       (reti),
        .irq_o        (irq),
        .irq_id_o     (id)
    );

    function automatic int m_code();
        return {m_prio[4], m_prio[3], m_prio[0]};
    endfunction

    function automatic bit m_irq(input logic [5:0] p);
        int c = m_code();
        return (c != 0) && (c != 7) && m_master && ((p & m_en) != 0);
    endfunction

    function automatic int m_win(input logic [5:0] p);
        string ord;
        logic [5:0] q = p & m_en;
        case (m_code())
            1: ord = "CAB";
            2: ord = "ABC";
            3: ord = "ACB";
            4: ord = "BCA";
            5: ord = "CBA";
            6: ord = "BAC";
            default: ord = "ABC";
        endcase
        for (int i = 0; i < 3; i++) begin
            int a, b;
            if (ord[i] == "A") begin
                a = m_prio[5] ? 3 : 5; b = m_prio[5] ? 5 : 3;
            end else if (ord[i] == "B") begin
                a = m_prio[2] ? 0 : 2; b = m_prio[2] ? 2 : 0;
            end else begin
                a = m_prio[1] ? 4 : 1; b = m_prio[1] ? 1 : 4;
            end
            if (q[a]) return a;
            if (q[b]) return b;
        end
        return 0;
    endfunction

    // Advance the model at each rising edge from the sampled inputs.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_en = 0; m_master = 0; m_prio = 0; m_id = 0;
        end else begin
            if (ack && m_irq(pend)) m_id = 3'(m_win(pend));
            if (di || ack)        m_master = 0;
            else if (ei || reti)  m_master = 1;
            else if (mwr)         m_master = mdata[7];
            if (mwr) m_en = mdata[5:0];
            if (pwr) m_prio = pdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare both outputs with the model at every falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk(irq == m_irq(pend), cur_req, "irq_o", int'(irq), int'(m_irq(pend)));
            chk(id == m_id, cur_req, "irq_id_o", int'(id), int'(m_id));
        end
    end

    // Watchdog ends a hung run as a failure.
    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc == 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_mask(input logic [7:0] d);
        mwr = 1; mdata = d; step(); mwr = 0;
    endtask

    task automatic wr_prio(input logic [5:0] d);
        pwr = 1; pdata = d; step(); pwr = 0;
    endtask

    initial begin
        rst_n = 0; pend = 6'h3F; mwr = 0; mdata = 0; pwr = 0; pdata = 0;
        ei = 0; di = 0; ack = 0; reti = 0;
        repeat (3) step();
        chk(irq == 0, "R1", "irq in reset", irq, 0);
        chk(id == 0, "R1", "id in reset", id, 0);
        ack = 1; rst_n = 1; step(); ack = 0;
        chk(irq == 0, "R1", "irq after reset", irq, 0);
        chk(id == 0, "R1", "id after reset", id, 0);

        // Unused codes 000 and 111 block everything
        cur_req = "R7";
        wr_mask(8'hFF);
        chk(irq == 0, "R7", "code 000", irq, 0);
        wr_prio(6'b011001);
        chk(irq == 0, "R7", "code 111", irq, 0);

        // Write with master set takes effect next edge
        cur_req = "R12";
        wr_prio(6'b001000);
        chk(irq == 1, "R12", "write while enabled", irq, 1);
        pend = 6'h00; #1;
        chk(irq == 0, "R12", "same-cycle pending drop", irq, 0);
        pend = 6'h3F; #1;

        // Master enable gates all
        cur_req = "R3";
        wr_mask(8'h3F);
        chk(irq == 0, "R3", "master off", irq, 0);

        cur_req = "R4";
        ei = 1; step(); ei = 0;
        chk(irq == 1, "R4", "ei sets", irq, 1);
        di = 1; step(); di = 0;
        chk(irq == 0, "R4", "di clears", irq, 0);
        ei = 1; di = 1; step(); ei = 0; di = 0;
        chk(irq == 0, "R4", "di beats ei", irq, 0);
        ei = 1; step(); ei = 0;

        // Per-source enables, bit 6 ignored
        cur_req = "R2";
        for (int i = 0; i < 6; i++) begin
            pend = 6'(1 << i);
            wr_mask({2'b11, ~6'(1 << i)});
            chk(irq == 0, "R2", "source disabled", irq, 0);
            wr_mask({2'b10, 6'(1 << i)});
            chk(irq == 1, "R2", "source enabled", irq, 1);
        end

        // Acknowledge and return
        cur_req = "R5";
        wr_mask(8'hBF);
        pend = 6'h3F;
        ack = 1; reti = 1; step(); ack = 0; reti = 0;
        chk(irq == 0, "R5", "ack beats reti", irq, 0);
        chk(id == 5, "R11", "winner code 010", id, 5);
        pend = 6'h01; ack = 1; step(); ack = 0;
        chk(id == 5, "R11", "hold without irq", id, 5);
        reti = 1; step(); reti = 0;
        chk(irq == 1, "R5", "reti sets", irq, 1);
        mwr = 1; mdata = 8'h3F; ei = 1; step(); mwr = 0; ei = 0;
        chk(irq == 1, "R5", "ei beats write bit 7", irq, 1);

        // Full priority sweep
        cur_req = "R6 R8 R9 R10 R11";
        wr_mask(8'hBF);
        for (int c = 1; c < 7; c++) begin
            for (int s = 0; s < 8; s++) begin
                wr_prio({s[2], c[2], c[1], s[1], s[0], c[0]});
                for (int p = 1; p < 64; p++) begin
                    pend = 6'(p);
                    ack = 1; step(); ack = 0;
                    reti = 1; step(); reti = 0;
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule